// File: doc/BRIEF.md
# Touch Pen Interrupt Arming Control

This block decides when the pen-detect interrupt of a resistive touch controller is live. When it is armed, the touch-sense pin is tied to the detect path with the low-side driver on, and the interrupt pin goes low while the panel is pressed. The block watches three things: the write-address acknowledge from the serial slave, the decoded command byte (a 4-bit command code, a power-down select bit and a resolution bit), and the end of the transfer, which is STOP or repeated START. From these it decides when the interrupt is disarmed, when it is armed again, and when it is held low.

Each command that is not a driver-only command starts a conversion when its transfer ends. A cycle counter, set by a parameter, models the conversion time. The 12-bit and 8-bit resolutions have separate counts. When the conversion finishes, the interrupt is armed again only if that command's power-down select bit was 0. Driver-only commands start no conversion. They keep the detector off and hold the interrupt pin low until the next write address is acknowledged. The analog touch sensing is modelled by one digital input. The pin is modelled as a level: 0 means pulled low, 1 means released.

Top module: `pen_irq_ctrl`

## Requirements
- R1: After reset, pen_det_en=0, irq_force_low=0 and pen_irq_n=1. The detector stays off until the first command with cmd_pd0=0 completes its conversion.
- R2: While pen_det_en=1 and irq_force_low=0, pen_irq_n equals the inverse of panel_touched in the same cycle.
- R3: In the cycle after wr_addr_ack is sampled high, pen_det_en=0 and irq_force_low=0.
- R4: A conversion command with cmd_pd0=0 and cmd_8bit=0 sets pen_det_en=1 exactly CONV_CYC_12 cycles after the cycle in which xfer_end is sampled. With cmd_8bit=1 the delay is CONV_CYC_8 cycles.
- R5: A conversion command with cmd_pd0=1 leaves pen_det_en=0 after its conversion completes. It stays 0 until a later command with cmd_pd0=0 completes.
- R6: Codes 4'b1000, 4'b1001 and 4'b1010 are driver-only. Whatever cmd_pd0 is, the cycle after such a command byte shows irq_force_low=1, pen_det_en=0 and pen_irq_n=0. No conversion follows and the detector is not armed. The force is released by the next wr_addr_ack.
- R7: pen_det_en stays 0 through every cycle of a conversion, including the position codes 4'b1100 to 4'b1111.
- R8: If wr_addr_ack arrives during a conversion, or in the cycle where the conversion completes, that completion does not arm the detector.
- R9: An xfer_end with no command byte received since the last wr_addr_ack has no effect on pen_det_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_addr_ack | input | 1 | One-cycle strobe: write address acknowledged |
| cmd_valid | input | 1 | One-cycle strobe: command byte received |
| cmd_code | input | 4 | Command code, bit 3 first |
| cmd_pd0 | input | 1 | Power-down select of the command (1 keeps detector off) |
| cmd_8bit | input | 1 | Resolution select (1 = 8-bit, shorter conversion) |
| xfer_end | input | 1 | One-cycle strobe: STOP or repeated START seen |
| panel_touched | input | 1 | Digital model of the panel being pressed |
| pen_det_en | output | 1 | Sense pin on detect path, low-side driver on |
| irq_force_low | output | 1 | Hold the interrupt pin low |
| pen_irq_n | output | 1 | Interrupt pin level (0 = low) |

## Verification
Two events can fall in the same cycle: the end of a conversion, which would arm the detector, and a new write-address acknowledge, which disarms it. The bench provokes this by starting a conversion with the select bit at 0 and timing the acknowledge strobe so that the design samples it on the exact edge where the count runs out. The expected result is that pen_det_en stays 0 at that point and afterwards. An acknowledge placed in the middle of a conversion is checked in the same way.

// File: rtl/pen_irq_pkg.sv
package pen_irq_pkg;

  typedef enum logic [1:0] {
    CLS_CONV = 2'd0,
    CLS_POS  = 2'd1,
    CLS_DRV  = 2'd2
  } cmd_class_e;

  // Driver-only commands: 1000, 1001, 1010
  function automatic cmd_class_e classify(input logic [3:0] code);
    if (code[3] && !code[2] && !(code[1] && code[0])) return CLS_DRV;
    if (code[3] && code[2]) return CLS_POS;
    return CLS_CONV;
  endfunction

  function automatic logic is_driver_only(input logic [3:0] code);
    return classify(code) == CLS_DRV;
  endfunction

endpackage

// File: rtl/pen_cmd_latch.sv
module pen_cmd_latch
  import pen_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_addr_ack,
  input  logic       cmd_valid,
  input  logic [3:0] cmd_code,
  input  logic       cmd_pd0,
  input  logic       cmd_8bit,
  input  logic       xfer_end,
  output logic       drv_cmd,
  output logic       start_conv,
  output logic       start_pd0,
  output logic       start_8bit
);
  logic pend_valid, pend_drv, pend_pd0, pend_8bit;

  assign drv_cmd    = cmd_valid && !wr_addr_ack && (classify(cmd_code) == CLS_DRV);
  assign start_conv = xfer_end && !wr_addr_ack && !cmd_valid && pend_valid && !pend_drv;
  assign start_pd0  = pend_pd0;
  assign start_8bit = pend_8bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_drv   <= 1'b0;
      pend_pd0   <= 1'b1;
      pend_8bit  <= 1'b0;
    end else if (wr_addr_ack) begin
      pend_valid <= 1'b0;
    end else if (cmd_valid) begin
      pend_valid <= 1'b1;
      pend_drv   <= (classify(cmd_code) == CLS_DRV);
      pend_pd0   <= cmd_pd0;
      pend_8bit  <= cmd_8bit;
    end else if (xfer_end) begin
      pend_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pen_conv_timer.sv
module pen_conv_timer #(
  parameter int CONV_CYC_12 = 2000,
  parameter int CONV_CYC_8  = 1400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mode8,
  output logic conv_busy,
  output logic conv_done
);
  localparam int MAXC  = (CONV_CYC_12 > CONV_CYC_8) ? CONV_CYC_12 : CONV_CYC_8;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  assign load_val  = mode8 ? CNT_W'(CONV_CYC_8) : CNT_W'(CONV_CYC_12);
  assign conv_busy = (cnt != '0);
  assign conv_done = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (start)     cnt <= load_val;
    else if (conv_busy) cnt <= cnt - CNT_W'(1);
  end
endmodule

// File: rtl/pen_arm_fsm.sv
module pen_arm_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_addr_ack,
  input  logic drv_cmd,
  input  logic start_conv,
  input  logic start_pd0,
  input  logic conv_done,
  output logic armed,
  output logic force_low,
  output logic arm_block
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      force_low <= 1'b0;
      arm_block <= 1'b1;
    end else if (wr_addr_ack) begin
      armed     <= 1'b0;
      force_low <= 1'b0;
      arm_block <= 1'b1;
    end else if (drv_cmd) begin
      armed     <= 1'b0;
      force_low <= 1'b1;
    end else if (start_conv) begin
      armed     <= 1'b0;
      arm_block <= start_pd0;
    end else if (conv_done) begin
      armed     <= !arm_block;
    end
  end
endmodule

// File: rtl/pen_irq_ctrl.sv
module pen_irq_ctrl #(
  parameter int CONV_CYC_12 = 2000,
  parameter int CONV_CYC_8  = 1400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_addr_ack,
  input  logic       cmd_valid,
  input  logic [3:0] cmd_code,
  input  logic       cmd_pd0,
  input  logic       cmd_8bit,
  input  logic       xfer_end,
  input  logic       panel_touched,
  output logic       pen_det_en,
  output logic       irq_force_low,
  output logic       pen_irq_n
);
  logic drv_cmd, start_conv, start_pd0, start_8bit;
  logic conv_busy, conv_done, arm_block;

  pen_cmd_latch u_latch (
    .clk(clk), .rst_n(rst_n), .wr_addr_ack(wr_addr_ack), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_pd0(cmd_pd0), .cmd_8bit(cmd_8bit), .xfer_end(xfer_end),
    .drv_cmd(drv_cmd), .start_conv(start_conv), .start_pd0(start_pd0),
    .start_8bit(start_8bit)
  );

  pen_conv_timer #(.CONV_CYC_12(CONV_CYC_12), .CONV_CYC_8(CONV_CYC_8)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_conv), .mode8(start_8bit),
    .conv_busy(conv_busy), .conv_done(conv_done)
  );

  pen_arm_fsm u_arm (
    .clk(clk), .rst_n(rst_n), .wr_addr_ack(wr_addr_ack), .drv_cmd(drv_cmd),
    .start_conv(start_conv), .start_pd0(start_pd0), .conv_done(conv_done),
    .armed(pen_det_en), .force_low(irq_force_low), .arm_block(arm_block)
  );

  assign pen_irq_n = !(irq_force_low || (pen_det_en && panel_touched));
endmodule

// File: rtl/pen_irq_ctrl_chk.sv
module pen_irq_ctrl_chk
  import pen_irq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_addr_ack,
  input logic       cmd_valid,
  input logic [3:0] cmd_code,
  input logic       pen_det_en,
  input logic       irq_force_low,
  input logic       conv_busy,
  input logic       conv_done,
  input logic       arm_block
);
  p_ack_disarms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr_ack |=> (!pen_det_en && !irq_force_low));

  p_drv_forces_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !wr_addr_ack && is_driver_only(cmd_code)) |=> (irq_force_low && !pen_det_en));

  p_force_no_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_force_low |-> !pen_det_en);

  p_busy_disarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |-> !pen_det_en);

  p_arm_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pen_det_en) |-> $past(conv_done && !arm_block));
endmodule

bind pen_irq_ctrl pen_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_addr_ack(wr_addr_ack), .cmd_valid(cmd_valid),
  .cmd_code(cmd_code), .pen_det_en(pen_det_en), .irq_force_low(irq_force_low),
  .conv_busy(conv_busy), .conv_done(conv_done), .arm_block(arm_block)
);

// File: tb/pen_irq_ctrl_test.sv
`timescale 1ns/1ps
module pen_irq_ctrl_test;
  localparam int C12 = 2000;
  localparam int C8  = 1400;

  logic clk = 0, rst_n = 0;
  logic wr_addr_ack = 0, cmd_valid = 0, cmd_pd0 = 0, cmd_8bit = 0, xfer_end = 0;
  logic panel_touched = 0;
  logic [3:0] cmd_code = 0;
  logic pen_det_en, irq_force_low, pen_irq_n;

  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  pen_irq_ctrl #(.CONV_CYC_12(C12), .CONV_CYC_8(C8)) uut (.*);

  // behavioural reference model
  int m_arm, m_force, m_block, m_pend, m_drv, m_pd0, m_m8, m_cnt;
  bit m_done;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_arm = 0; m_force = 0; m_block = 1; m_pend = 0; m_cnt = 0;
      m_drv = 0; m_pd0 = 1; m_m8 = 0;
    end else begin
      m_done = (m_cnt == 1);
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (wr_addr_ack) begin
        m_arm = 0; m_force = 0; m_block = 1; m_pend = 0;
      end else if (cmd_valid) begin
        m_pend = 1; m_pd0 = cmd_pd0; m_m8 = cmd_8bit;
        m_drv = (cmd_code == 4'd8 || cmd_code == 4'd9 || cmd_code == 4'd10);
        if (m_drv) begin m_force = 1; m_arm = 0; end
      end else if (xfer_end) begin
        if (m_pend && !m_drv) begin
          m_cnt = m_m8 ? C8 : C12; m_arm = 0; m_block = m_pd0;
        end
        m_pend = 0;
      end else if (m_done) begin
        m_arm = !m_block;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // compare against model on every clock, away from the edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R4 model pen_det_en", pen_det_en, m_arm);
      check("R6 model irq_force_low", irq_force_low, m_force);
      check("R2 model pen_irq_n", pen_irq_n, !(m_force || (m_arm && panel_touched)));
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic p_ack();
    wr_addr_ack = 1; @(negedge clk); wr_addr_ack = 0;
  endtask

  task automatic p_cmd(input logic [3:0] c, input logic pd0, input logic m8);
    cmd_code = c; cmd_pd0 = pd0; cmd_8bit = m8; cmd_valid = 1;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic p_end();
    xfer_end = 1; @(negedge clk); xfer_end = 0;
  endtask

  // full write transfer; returns at the negedge after xfer_end was sampled
  task automatic write_cmd(input logic [3:0] c, input logic pd0, input logic m8);
    p_ack(); idle(2); p_cmd(c, pd0, m8); idle(2); p_end();
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    panel_touched = 1;
    idle(1); #1;
    check("R1 reset pen_det_en", pen_det_en, 0);
    check("R1 reset irq_force_low", irq_force_low, 0);
    check("R1 reset pen_irq_n", pen_irq_n, 1);

    // R9: stray transfer end after reset
    p_end(); idle(20);
    check("R9 stray xfer_end", pen_det_en, 0);
    check("R1 still disabled", pen_det_en, 0);

    // R4 12-bit X position, pd0=0
    write_cmd(4'b1100, 0, 0);
    idle(C12 / 2);
    check("R7 mid X conversion", pen_det_en, 0);
    idle(C12 - 1 - C12 / 2);
    check("R4 12b one cycle early", pen_det_en, 0);
    idle(1);
    check("R4 12b armed on time", pen_det_en, 1);

    // R2 follows touch
    panel_touched = 1; #1;
    check("R2 touched low", pen_irq_n, 0);
    idle(1); panel_touched = 0; #1;
    check("R2 released high", pen_irq_n, 1);

    // R3 ack disarms
    p_ack(); #1;
    check("R3 ack disarms", pen_det_en, 0);

    // R4 8-bit temperature code 0000
    idle(2); p_cmd(4'b0000, 0, 1); idle(2); p_end();
    idle(C8 - 1);
    check("R4 8b one cycle early", pen_det_en, 0);
    idle(1);
    check("R4 8b armed on time", pen_det_en, 1);

    // R5 pd0=1 keeps detector off
    write_cmd(4'b1101, 1, 0);
    idle(C12 + 5);
    check("R5 pd0=1 stays off", pen_det_en, 0);
    p_end(); idle(10);
    check("R9 xfer_end after completion", pen_det_en, 0);
    write_cmd(4'b0001, 0, 0);
    idle(C12);
    check("R5 later pd0=0 rearms", pen_det_en, 1);

    // R6 driver-only codes
    for (int k = 8; k <= 10; k++) begin
      panel_touched = 0;
      p_ack(); idle(1); p_cmd(4'(k), 4'(k) == 4'd9 ? 1'b0 : 1'b1, 0); #1;
      check("R6 force set", irq_force_low, 1);
      check("R6 pin low untouched", pen_irq_n, 0);
      check("R6 detector off", pen_det_en, 0);
      idle(1); p_end(); idle(C12 + 5);
      check("R6 no arming after driver cmd", pen_det_en, 0);
      check("R6 force held", irq_force_low, 1);
      p_ack(); #1;
      check("R6 force released by ack", irq_force_low, 0);
      check("R6 pin released", pen_irq_n, 1);
    end

    // R8 ack in the middle of a conversion
    write_cmd(4'b1110, 0, 0);
    idle(C12 / 3); p_ack();
    idle(C12);
    check("R8 mid-conversion ack blocks arm", pen_det_en, 0);

    // R8 ack in the completion cycle
    idle(1); p_cmd(4'b1111, 0, 0); idle(1); p_end();
    idle(C12 - 1);
    check("R7 Z2 conversion end-1", pen_det_en, 0);
    p_ack();
    check("R8 same-cycle ack wins", pen_det_en, 0);
    idle(20);
    check("R8 stays off after collision", pen_det_en, 0);

    // recover: normal arm still works
    idle(1); p_cmd(4'b0011, 0, 1); idle(1); p_end();
    idle(C8);
    check("R4 arm after collision", pen_det_en, 1);

    idle(5);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule